// File: doc/BRIEF.md
# PCI Configuration Address Decoder

This block is the host-side front end for PCI configuration cycles. It presents two windows on a simple register bus. Software writes a 32-bit configuration tag into the address window. The block keeps that tag and turns it into bus, device, function and register numbers. Accesses to the data window are then forwarded to the configuration targets at those numbers.

A tag can be written in one of two forms, chosen by bit 0 of the tag. Bit 0 set means a binary form with explicit bus and device fields. Bit 0 clear means a local form: the bus is 0, and the device is picked by the lowest set bit from bit 11 upward. The host bus carries data in big-endian lane order, while configuration data is little-endian, so every byte lane is mirrored in both directions.

Writes to the data window are posted with their byte enables. Reads hold the host bus until the target answers. A tag that cannot be decoded raises an error flag and suppresses target accesses.

Top module: `cfg_portal`

## Requirements
- R1: After reset the stored tag is 0, `cfg_err` is 0, `tg_req` is 0, and the coordinates count as invalid until a nonzero decodable tag has been written.
- R2: The address window is the doubleword at offset 0xC00000 (`hb_addr` = 0x180000). Any access to it is acknowledged in the same cycle. A write stores the tag taken little-endian from `hb_wdata[31:0]`: byte `[7:0]` becomes tag bits 31:24 and byte `[31:24]` becomes tag bits 7:0. A read returns the stored tag, unchanged, in the same byte order in `hb_rdata[31:0]`, with `hb_rdata[63:32]` equal to 0.
- R3: A tag with bit 0 set decodes as follows: bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:1 followed by a 0.
- R4: A tag with bit 0 clear decodes as bus 0, with device equal to the index of the lowest set bit among bits 11 to 31. The function is bits 10:8 and the register is bits 7:0.
- R5: A nonzero tag with bit 0 clear and no bit set in 11 to 31 sets `cfg_err` and marks the coordinates invalid. While the coordinates are invalid, a data-window access is acknowledged in the same cycle, issues no `tg_req`, reads all ones, and sets `cfg_err`.
- R6: Writing a tag of 0 stores it, but leaves the coordinates, their validity and `cfg_err` unchanged.
- R7: A data-window write (`hb_addr` = 0x1C0000) with valid coordinates is acknowledged in the same cycle. In the next cycle `tg_req` is high for exactly one cycle, with `tg_we`=1. `tg_wdata` byte lane i carries host lane 7−i, and `tg_be` bit i equals `hb_be` bit 7−i.
- R8: A data-window read with valid coordinates withholds `hb_ack` until the target answers. In the cycle after the request, `tg_req` pulses for one cycle with `tg_we`=0. In the cycle after `tg_rsp_valid`, `hb_ack` is 1 and `hb_rdata` lane i carries `tg_rdata` lane 7−i.
- R9: `tg_self` is 1 exactly when the current coordinates are bus 0, device 31, function 0.
- R10: An access to any other offset is acknowledged in the same cycle, reads 0 and changes nothing.
- R11: Writing a nonzero decodable tag clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_req | input | 1 | Host access request, held until `hb_ack` |
| hb_we | input | 1 | Host write (1) or read (0) |
| hb_addr | input | 21 | Doubleword index of the window offset |
| hb_be | input | 8 | Host byte enables, big-endian lanes |
| hb_wdata | input | 64 | Host write data, big-endian lanes |
| hb_ack | output | 1 | Access complete |
| hb_rdata | output | 64 | Host read data, valid with `hb_ack` |
| tg_req | output | 1 | One-cycle configuration request |
| tg_we | output | 1 | Request is a write |
| tg_bus | output | 8 | Decoded bus number |
| tg_dev | output | 5 | Decoded device number |
| tg_fn | output | 3 | Decoded function number |
| tg_reg | output | 8 | Decoded register offset |
| tg_be | output | 8 | Byte enables, little-endian lanes |
| tg_wdata | output | 64 | Write data, little-endian lanes |
| tg_self | output | 1 | Coordinates address the controller's own function |
| tg_rsp_valid | input | 1 | Target read response strobe |
| tg_rdata | input | 64 | Target read data, little-endian lanes |
| cfg_err | output | 1 | Undecodable tag or access without valid coordinates |

## Verification
Some properties are checked on every cycle. `tg_req` never lasts more than one cycle, and it never rises while `cfg_err` is set. `hb_ack` stays low while a read waits on the target, and a read completion always follows a target response. A zero tag never moves the coordinates, and a local-form decode always names a device bit that is actually set. Other behaviour can only be shown by the bench scenarios: the values of the two decode forms, the lowest-bit priority with several bits set, the lane mirroring of data and enables, read stalls of different lengths, and recovery of the error flag.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int TAG_W  = 32;
    localparam int DEV_LO = 11;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [7:0] regno;
    } cfg_coord_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } txn_state_e;

    function automatic logic is_self(input cfg_coord_t c, input logic [4:0] self_dev);
        return (c.bus == 8'd0) && (c.dev == self_dev) && (c.fn == 3'd0);
    endfunction

endpackage

// File: rtl/cfgp_byterev.sv
module cfgp_byterev #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = din[(LANES-1-g)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/cfgp_tag_decode.sv
module cfgp_tag_decode
    import cfgp_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    output cfg_coord_t       coord,
    output logic             ok
);
    logic       hit;
    logic [4:0] low_dev;

    always_comb begin
        hit     = 1'b0;
        low_dev = 5'd0;
        for (int i = TAG_W - 1; i >= DEV_LO; i--) begin
            if (tag[i]) begin
                hit     = 1'b1;
                low_dev = 5'(i);
            end
        end
    end

    always_comb begin
        if (tag[0]) begin
            coord.bus   = tag[23:16];
            coord.dev   = tag[15:11];
            coord.fn    = tag[10:8];
            coord.regno = {tag[7:1], 1'b0};
            ok          = 1'b1;
        end else begin
            coord.bus   = 8'd0;
            coord.dev   = low_dev;
            coord.fn    = tag[10:8];
            coord.regno = tag[7:0];
            ok          = hit;
        end
    end

    // R4: a local-form result names a device bit that is really set
    always_comb begin
        if (!$isunknown(tag) && ok && !tag[0]) begin
            a_dev_bit_set_r4: assert (tag[coord.dev] && coord.dev >= 5'(DEV_LO))
                else $error("local-form decode chose a clear bit");
        end
    end
endmodule

// File: rtl/cfg_portal.sv
module cfg_portal
    import cfgp_pkg::*;
#(
    parameter int               OFS_W         = 24,
    parameter int               DATA_BYTES    = 8,
    parameter logic [OFS_W-1:0] ADDR_PORT_OFS = 24'hC00000,
    parameter logic [OFS_W-1:0] DATA_PORT_OFS = 24'hE00000,
    parameter logic [4:0]       SELF_DEV      = 5'd31
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hb_req,
    input  logic                    hb_we,
    input  logic [OFS_W-4:0]        hb_addr,
    input  logic [DATA_BYTES-1:0]   hb_be,
    input  logic [DATA_BYTES*8-1:0] hb_wdata,
    output logic                    hb_ack,
    output logic [DATA_BYTES*8-1:0] hb_rdata,
    output logic                    tg_req,
    output logic                    tg_we,
    output logic [7:0]              tg_bus,
    output logic [4:0]              tg_dev,
    output logic [2:0]              tg_fn,
    output logic [7:0]              tg_reg,
    output logic [DATA_BYTES-1:0]   tg_be,
    output logic [DATA_BYTES*8-1:0] tg_wdata,
    output logic                    tg_self,
    input  logic                    tg_rsp_valid,
    input  logic [DATA_BYTES*8-1:0] tg_rdata,
    output logic                    cfg_err
);
    localparam int DATA_W  = DATA_BYTES * 8;
    localparam int TAG_BYT = TAG_W / 8;

    txn_state_e        state_q;
    logic [TAG_W-1:0]  tag_q;
    cfg_coord_t        coord_q;
    logic              cvalid_q;
    logic              err_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              treq_q;
    logic              twe_q;
    logic [DATA_BYTES-1:0] tbe_q;
    logic [DATA_W-1:0] twdata_q;

    logic [TAG_W-1:0]  wtag, tag_host;
    logic [DATA_W-1:0] wdata_le, rdata_host;
    logic [DATA_BYTES-1:0] be_le;
    cfg_coord_t        dec_coord;
    logic              dec_ok;

    cfgp_byterev #(.LANES(TAG_BYT), .LANE_W(8)) i_tag_in (
        .din(hb_wdata[TAG_W-1:0]), .dout(wtag));
    cfgp_byterev #(.LANES(TAG_BYT), .LANE_W(8)) i_tag_out (
        .din(tag_q), .dout(tag_host));
    cfgp_byterev #(.LANES(DATA_BYTES), .LANE_W(8)) i_wdata (
        .din(hb_wdata), .dout(wdata_le));
    cfgp_byterev #(.LANES(DATA_BYTES), .LANE_W(1)) i_be (
        .din(hb_be), .dout(be_le));
    cfgp_byterev #(.LANES(DATA_BYTES), .LANE_W(8)) i_rdata (
        .din(rbuf_q), .dout(rdata_host));

    cfgp_tag_decode i_dec (
        .tag(wtag), .coord(dec_coord), .ok(dec_ok));

    logic idle, sel_addr, sel_data, acc_addr, acc_data, acc_other;

    assign idle      = (state_q == ST_IDLE);
    assign sel_addr  = (hb_addr == ADDR_PORT_OFS[OFS_W-1:3]);
    assign sel_data  = (hb_addr == DATA_PORT_OFS[OFS_W-1:3]);
    assign acc_addr  = hb_req && idle && sel_addr;
    assign acc_data  = hb_req && idle && sel_data;
    assign acc_other = hb_req && idle && !sel_addr && !sel_data;

    always_comb begin
        hb_ack   = 1'b0;
        hb_rdata = '0;
        if (state_q == ST_DONE) begin
            hb_ack   = 1'b1;
            hb_rdata = rdata_host;
        end else if (acc_addr) begin
            hb_ack = 1'b1;
            if (!hb_we) hb_rdata[TAG_W-1:0] = tag_host;
        end else if (acc_other) begin
            hb_ack = 1'b1;
        end else if (acc_data && (hb_we || !cvalid_q)) begin
            hb_ack = 1'b1;
            if (!hb_we && !cvalid_q) hb_rdata = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tag_q    <= '0;
            coord_q  <= '0;
            cvalid_q <= 1'b0;
            err_q    <= 1'b0;
            rbuf_q   <= '0;
            treq_q   <= 1'b0;
            twe_q    <= 1'b0;
            tbe_q    <= '0;
            twdata_q <= '0;
        end else begin
            treq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_addr && hb_we) begin
                        tag_q <= wtag;
                        if (wtag != '0) begin
                            cvalid_q <= dec_ok;
                            err_q    <= !dec_ok;
                            if (dec_ok) coord_q <= dec_coord;
                        end
                    end
                    if (acc_data) begin
                        if (!cvalid_q) begin
                            err_q <= 1'b1;
                        end else begin
                            treq_q   <= 1'b1;
                            twe_q    <= hb_we;
                            tbe_q    <= be_le;
                            twdata_q <= hb_we ? wdata_le : '0;
                            if (!hb_we) state_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tg_rsp_valid) begin
                        rbuf_q  <= tg_rdata;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign tg_req   = treq_q;
    assign tg_we    = twe_q;
    assign tg_be    = tbe_q;
    assign tg_wdata = twdata_q;
    assign tg_bus   = coord_q.bus;
    assign tg_dev   = coord_q.dev;
    assign tg_fn    = coord_q.fn;
    assign tg_reg   = coord_q.regno;
    assign tg_self  = is_self(coord_q, SELF_DEV);
    assign cfg_err  = err_q;

    p_req_single_r7: assert property (@(posedge clk) disable iff (rst)
        tg_req |=> !tg_req);
    p_no_req_on_err_r5: assert property (@(posedge clk) disable iff (rst)
        tg_req |-> !cfg_err);
    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !hb_ack);
    p_done_after_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |-> $past(tg_rsp_valid));
    p_zero_tag_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_addr && hb_we && wtag == '0) |=> ($stable(coord_q) && $stable(cfg_err)));
endmodule

// File: tb/test_cfg_portal.sv
`timescale 1ns/1ps
module test_cfg_portal;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hb_req = 1'b0, hb_we = 1'b0;
    logic [20:0] hb_addr = '0;
    logic [7:0]  hb_be = '0;
    logic [63:0] hb_wdata = '0;
    logic        hb_ack;
    logic [63:0] hb_rdata;
    logic        tg_req, tg_we, tg_self, cfg_err;
    logic [7:0]  tg_bus, tg_reg, tg_be;
    logic [4:0]  tg_dev;
    logic [2:0]  tg_fn;
    logic [63:0] tg_wdata;
    logic        tg_rsp_valid = 1'b0;
    logic [63:0] tg_rdata = '0;

    localparam logic [20:0] A_ADDR = 21'h180000;
    localparam logic [20:0] A_DATA = 21'h1C0000;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_tag = 0, m_bus = 0, m_dev = 0, m_fn = 0, m_reg = 0;
    bit m_valid = 0, m_err = 0;

    always #2.5 clk = ~clk;

    cfg_portal i_cfg_portal (
        .clk(clk), .rst(rst), .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr),
        .hb_be(hb_be), .hb_wdata(hb_wdata), .hb_ack(hb_ack), .hb_rdata(hb_rdata),
        .tg_req(tg_req), .tg_we(tg_we), .tg_bus(tg_bus), .tg_dev(tg_dev),
        .tg_fn(tg_fn), .tg_reg(tg_reg), .tg_be(tg_be), .tg_wdata(tg_wdata),
        .tg_self(tg_self), .tg_rsp_valid(tg_rsp_valid), .tg_rdata(tg_rdata),
        .cfg_err(cfg_err));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mirror(input logic [63:0] v, input int nb);
        logic [63:0] r = '0;
        for (int b = 0; b < nb; b++) r[8*b +: 8] = v[8*(nb-1-b) +: 8];
        return r;
    endfunction

    function automatic logic [7:0] mirror_be(input logic [7:0] v);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = v[7-b];
        return r;
    endfunction

    // model of tag write
    task automatic model_tag(input int t);
        int d = -1;
        m_tag = t;
        if (t == 0) return;
        if (t[0]) begin
            m_bus = (t >> 16) & 255; m_dev = (t >> 11) & 31;
            m_fn = (t >> 8) & 7; m_reg = t & 254;
            m_valid = 1; m_err = 0;
        end else begin
            for (int i = 11; i < 32; i++) if (d < 0 && t[i]) d = i;
            if (d < 0) begin
                m_valid = 0; m_err = 1;
            end else begin
                m_bus = 0; m_dev = d; m_fn = (t >> 8) & 7; m_reg = t & 255;
                m_valid = 1; m_err = 0;
            end
        end
    endtask

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            chk("R5/R11 err", cfg_err, m_err);
            chk("R3/R4 coords", {tg_bus, tg_dev, tg_fn, tg_reg},
                {m_bus[7:0], m_dev[4:0], m_fn[2:0], m_reg[7:0]});
            chk("R9 self", tg_self, (m_bus == 0 && m_dev == 31 && m_fn == 0));
        end
    end

    task automatic addr_wr(input logic [31:0] t);
        @(negedge clk);
        hb_req = 1; hb_we = 1; hb_addr = A_ADDR; hb_be = 8'h0F;
        hb_wdata = {32'h0, mirror({32'h0, t}, 4)[31:0]};
        #1 chk("R2 addr write ack", hb_ack, 1);
        @(posedge clk); model_tag(t);
        @(negedge clk); hb_req = 0;
    endtask

    task automatic addr_rd();
        @(negedge clk);
        hb_req = 1; hb_we = 0; hb_addr = A_ADDR;
        #1 chk("R2 addr read ack", hb_ack, 1);
        chk("R2 tag readback", hb_rdata, {32'h0, mirror({32'h0, m_tag[31:0]}, 4)[31:0]});
        @(negedge clk); hb_req = 0;
    endtask

    task automatic data_wr(input logic [63:0] le, input logic [7:0] le_be);
        bit v = m_valid;
        @(negedge clk);
        hb_req = 1; hb_we = 1; hb_addr = A_DATA;
        hb_wdata = mirror(le, 8); hb_be = mirror_be(le_be);
        #1 chk("R7 write ack same cycle", hb_ack, 1);
        @(posedge clk); if (!v) m_err = 1;
        @(negedge clk); hb_req = 0;
        #1 chk(v ? "R7 tg_req pulse" : "R5 no request", tg_req, v);
        if (v) begin
            chk("R7 tg_we", tg_we, 1);
            chk("R7 wdata lanes", tg_wdata, le);
            chk("R7 be lanes", tg_be, le_be);
        end
        @(negedge clk); #1 chk("R7 single pulse", tg_req, 0);
    endtask

    task automatic data_rd(input logic [63:0] le, input int lat);
        @(negedge clk);
        hb_req = 1; hb_we = 0; hb_addr = A_DATA;
        if (!m_valid) begin
            #1 chk("R5 invalid read ack", hb_ack, 1);
            chk("R5 invalid read ones", hb_rdata, '1);
            @(posedge clk); m_err = 1;
            @(negedge clk); hb_req = 0;
            #1 chk("R5 no request", tg_req, 0);
            return;
        end
        #1 chk("R8 no ack before response", hb_ack, 0);
        @(negedge clk); #1 chk("R8 tg_req read", {tg_req, tg_we}, 2'b10);
        for (int k = 0; k < lat; k++) begin
            @(negedge clk); #1 chk("R8 stall", hb_ack, 0);
        end
        tg_rsp_valid = 1; tg_rdata = le;
        @(negedge clk); tg_rsp_valid = 0;
        #1 chk("R8 ack after response", hb_ack, 1);
        chk("R8 rdata lanes", hb_rdata, mirror(le, 8));
        hb_req = 0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 chk("R1 err after reset", cfg_err, 0);
        chk("R1 no request", tg_req, 0);
        addr_rd();                                   // R1: tag 0
        data_rd(64'h0, 0);                           // R1/R5: invalid before tag
        addr_wr({8'h00, 8'h5A, 5'h13, 3'h5, 8'h3D}); // R3, R11
        addr_rd();                                   // R2
        data_wr(64'h1122334455667788, 8'h0F);        // R7
        data_wr(64'hA5A5_0000_FFFF_1234, 8'hC1);     // R7
        data_rd(64'h0102030405060708, 0);            // R8
        data_rd(64'hDEADBEEF_CAFEF00D, 3);           // R8 stall
        addr_wr(32'h0010_2240);                      // R4: bits 13 and 20 -> dev 13
        addr_rd();
        addr_wr(32'h0);                              // R6
        addr_rd();
        data_wr(64'h55, 8'h01);                      // R6 coords still used
        addr_wr(32'h8000_0008);                      // R4/R9: dev 31
        addr_wr({8'h00, 8'h00, 5'd31, 3'd0, 8'h11}); // R9 binary form
        addr_wr({8'h00, 8'h01, 5'd31, 3'd0, 8'h11}); // R9 off
        addr_wr(32'h0000_0800);                      // R4 device 11
        addr_wr(32'h0000_0704);                      // R5 undecodable
        data_wr(64'h99, 8'hFF);                      // R5 no request
        data_rd(64'h0, 0);                           // R5 ones
        addr_wr(32'h0);                              // R6 err kept
        // R10: unmapped window
        @(negedge clk);
        hb_req = 1; hb_we = 1; hb_addr = 21'h000200; hb_wdata = '1;
        #1 chk("R10 unmapped write ack", hb_ack, 1);
        @(negedge clk); hb_we = 0;
        #1 chk("R10 unmapped read ack", hb_ack, 1);
        chk("R10 unmapped read zero", hb_rdata, 0);
        @(negedge clk); hb_req = 0;
        #1 chk("R10 no request", tg_req, 0);
        addr_rd();                                   // R10 tag unchanged
        addr_wr(32'h0000_4001);                      // R11 clears err
        data_rd(64'h0F0E0D0C0B0A0908, 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule